// File: doc/BRIEF.md
# Bidirectional Timer Counter Unit

This block holds the running value of an 8-bit timer. It counts up or down, or clears to zero, but only in a system-clock cycle in which the selected tick enable is high. A 3-bit source selector picks one of seven single-cycle tick-enable inputs, or none at all. When it picks none, the value is frozen. The surrounding mode logic supplies three controls: a count request, a direction and a clear request. A processor-side load port can overwrite the value in any cycle. A load wins over any tick action in the same cycle.

The unit drives the current value and two level detectors, one for the maximum and one for zero. Waveform logic can use them without decoding the value again. An overflow flag is set when an up-count wraps from the maximum to zero. The flag stays set until software writes a one to its acknowledge input. The flag is a two-state machine. State FLG_IDLE moves to state FLG_RAISED on transition RAISE, which is an up-count wrap. FLG_RAISED returns to FLG_IDLE on transition ACK, which is an acknowledge with no wrap in the same cycle. In every other case the state is held. In each cycle the next-value logic decodes exactly one action: ACT_LOAD, ACT_CLEAR, ACT_INC, ACT_DEC or ACT_HOLD.

Top module: `tcu_counter_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0x00 and `ovf_flag` becomes 0 on that edge.
- R2: When `clk_sel` is 0 and `wr_en` is low, `count` keeps its value whatever `tick_en`, `cnt_en`, `dir_down` and `clr` carry.
- R3: When `clk_sel` is k, with k from 1 to 7, a tick happens in a cycle only when `tick_en[k-1]` is high. The other bits of `tick_en` have no effect.
- R4: A tick with `clr` high sets `count` to 0x00 on the next edge, whatever `cnt_en` and `dir_down` are.
- R5: A tick with `clr` low and `cnt_en` high adds one to `count` when `dir_down` is 0 and subtracts one when `dir_down` is 1. The result is taken modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R6: With no tick, or with a tick while both `clr` and `cnt_en` are low, `count` keeps its value.
- R7: A cycle with `wr_en` high loads `wr_data` into `count` on the next edge. This takes priority over any clear or count action in that cycle, and it works for every `clk_sel` value.
- R8: `at_top` is high exactly while `count` is 0xFF, and `at_bottom` is high exactly while `count` is 0x00.
- R9: A tick that increments `count` from 0xFF to 0x00 with no load in that cycle sets `ovf_flag` on the same edge. A down-count wrap, a clear or a load never sets the flag. Once set, the flag stays high until it is acknowledged.
- R10: `ovf_ack` high clears `ovf_flag` on the next edge. When a wrap happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Tick source select; 0 stops counting |
| tick_en | input | 7 | Single-cycle tick enables, bit k-1 picked by select value k |
| cnt_en | input | 1 | Count request from mode logic |
| dir_down | input | 1 | 1 selects decrement, 0 increment |
| clr | input | 1 | Clear request from mode logic |
| wr_en | input | 1 | Processor load strobe |
| wr_data | input | 8 | Processor load value |
| ovf_ack | input | 1 | Write-one acknowledge of the overflow flag |
| count | output | 8 | Current counter value |
| at_top | output | 1 | Counter equals 0xFF |
| at_bottom | output | 1 | Counter equals 0x00 |
| ovf_flag | output | 1 | Sticky up-count wrap flag |

## Verification
The bench builds the block with its defaults: an 8-bit value and seven tick sources. At that size a full up or down wrap takes only 256 ticks, so both wrap points and both detectors are reached many times within the run. Every select value from 1 to 7 can also be stepped through with matching and non-matching tick patterns. Because the value is only 8 bits wide, the random phase reaches collisions between a load and a wrap, and between an acknowledge and a wrap, often enough to show the priority rules at work.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    // One action per system-clock cycle for the value register
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_CLEAR = 3'd2,
        ACT_INC   = 3'd3,
        ACT_DEC   = 3'd4
    } act_e;

    // Sticky wrap flag states
    typedef enum logic {
        FLG_IDLE   = 1'b0,
        FLG_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/tcu_tick_sel.sv
module tcu_tick_sel #(
    parameter int NUM_TICK = 7,
    parameter int SEL_W    = 3
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TICK-1:0] tick_in,
    output logic                tick
);

    logic [NUM_TICK-1:0] hit;

    // Each source is qualified by its own select code; code 0 matches nothing
    for (genvar i = 0; i < NUM_TICK; i++) begin : g_src
        assign hit[i] = (sel == SEL_W'(i + 1)) && tick_in[i];
    end

    assign tick = |hit;

endmodule

// File: rtl/tcu_action_dec.sv
module tcu_action_dec
    import tcu_pkg::*;
(
    input  logic tick,
    input  logic wr_en,
    input  logic clr,
    input  logic cnt_en,
    input  logic dir_down,
    output act_e act
);

    // Load has priority over any tick action, and clear over counting
    always_comb begin
        act = ACT_HOLD;
        if (wr_en) begin
            act = ACT_LOAD;
        end else if (tick) begin
            if (clr) begin
                act = ACT_CLEAR;
            end else if (cnt_en) begin
                act = dir_down ? ACT_DEC : ACT_INC;
            end
        end
    end

endmodule

// File: rtl/tcu_ovf_flag.sv
module tcu_ovf_flag
    import tcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic ack,
    output logic flag
);

    flag_state_e state_q, state_d;

    // Next-state logic: RAISE has priority over ACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (raise) state_d = FLG_RAISED;
            end
            FLG_RAISED: begin
                if (ack && !raise) state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLG_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLG_RAISED);
    end

    // R9: a wrap always leaves the flag set
    p_raise_sets_r9: assert property (@(posedge clk) disable iff (rst)
        raise |=> flag);

    // R9: without an acknowledge the flag never drops
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);

    // R10: an acknowledge with no wrap drops the flag
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !raise) |=> !flag);

endmodule

// File: rtl/tcu_counter_unit.sv
module tcu_counter_unit
    import tcu_pkg::*;
#(
    parameter  int WIDTH    = 8,
    parameter  int NUM_TICK = 7,
    localparam int SEL_W    = $clog2(NUM_TICK + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    clk_sel,
    input  logic [NUM_TICK-1:0] tick_en,
    input  logic                cnt_en,
    input  logic                dir_down,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [WIDTH-1:0]    wr_data,
    input  logic                ovf_ack,
    output logic [WIDTH-1:0]    count,
    output logic                at_top,
    output logic                at_bottom,
    output logic                ovf_flag
);

    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    logic             tick;
    act_e             act;
    logic [WIDTH-1:0] cnt_q, cnt_d;
    logic             wrap_up;

    tcu_tick_sel #(
        .NUM_TICK (NUM_TICK),
        .SEL_W    (SEL_W)
    ) u_tick_sel (
        .sel     (clk_sel),
        .tick_in (tick_en),
        .tick    (tick)
    );

    tcu_action_dec u_action_dec (
        .tick     (tick),
        .wr_en    (wr_en),
        .clr      (clr),
        .cnt_en   (cnt_en),
        .dir_down (dir_down),
        .act      (act)
    );

    always_comb begin
        cnt_d = cnt_q;
        unique case (act)
            ACT_HOLD:  cnt_d = cnt_q;
            ACT_LOAD:  cnt_d = wr_data;
            ACT_CLEAR: cnt_d = '0;
            ACT_INC:   cnt_d = cnt_q + ONE;
            ACT_DEC:   cnt_d = cnt_q - ONE;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign wrap_up = (act == ACT_INC) && (cnt_q == MAX_VAL);

    tcu_ovf_flag u_ovf_flag (
        .clk   (clk),
        .rst   (rst),
        .raise (wrap_up),
        .ack   (ovf_ack),
        .flag  (ovf_flag)
    );

    always_comb begin
        count     = cnt_q;
        at_top    = (cnt_q == MAX_VAL);
        at_bottom = (cnt_q == '0);
    end

    // R2: a stopped source freezes the value unless loaded
    p_stopped_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == '0 && !wr_en) |=> (count == $past(count)));

    // R4: a ticked clear reaches zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && clr && !wr_en) |=> (count == '0));

    // R5: ticked up-count steps by one modulo the width
    p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && cnt_en && !dir_down && !wr_en)
        |=> (count == WIDTH'($past(count) + ONE)));

    // R7: a load always lands on the next edge
    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_data)));

    // R8: the two detectors never fire together
    p_detect_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(at_top && at_bottom));

endmodule

// File: tb/tcu_counter_unit_tb.sv
module tcu_counter_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] clk_sel = '0;
    logic [6:0] tick_en = '0;
    logic       cnt_en = 1'b0;
    logic       dir_down = 1'b0;
    logic       clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ovf_ack = 1'b0;
    logic [7:0] count;
    logic       at_top;
    logic       at_bottom;
    logic       ovf_flag;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0;
    int m_flag = 0;

    always #5 clk = ~clk;

    tcu_counter_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .clk_sel   (clk_sel),
        .tick_en   (tick_en),
        .cnt_en    (cnt_en),
        .dir_down  (dir_down),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ovf_ack   (ovf_ack),
        .count     (count),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit tk;
        bit raise;
        tk = (clk_sel != 0) && tick_en[clk_sel - 1];
        if (rst) begin
            m_cnt  = 0;
            m_flag = 0;
        end else begin
            raise = !wr_en && tk && !clr && cnt_en && !dir_down && (m_cnt == 255);
            if (wr_en)       m_cnt = int'(wr_data);
            else if (tk) begin
                if (clr)         m_cnt = 0;
                else if (cnt_en) m_cnt = dir_down ? (m_cnt + 255) % 256 : (m_cnt + 1) % 256;
            end
            if (raise)        m_flag = 1;
            else if (ovf_ack) m_flag = 0;
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(cur_req, "count", int'(count), m_cnt);
            check("R8", "at_top", int'(at_top), int'(m_cnt == 255));
            check("R8", "at_bottom", int'(at_bottom), int'(m_cnt == 0));
            check(cur_req, "ovf_flag", int'(ovf_flag), m_flag);
        end
    endtask

    task automatic idle();
        clk_sel = 0; tick_en = '0; cnt_en = 0; dir_down = 0;
        clr = 0; wr_en = 0; ovf_ack = 0;
    endtask

    task automatic load(input int v);
        wr_en = 1; wr_data = 8'(v);
        cyc(1);
        wr_en = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        cnt_en = 1; tick_en = '1; clk_sel = 1;
        cyc(3);
        check("R1", "reset count", int'(count), 0);
        check("R1", "reset flag", int'(ovf_flag), 0);
        rst = 0; idle();
        cyc(1);

        // R7: load with a ticked clear in the same cycle
        cur_req = "R7";
        clk_sel = 2; tick_en = 7'b0000010; clr = 1; cnt_en = 1;
        load(8'hA5);
        check("R7", "load beats clear", int'(count), 8'hA5);
        idle();

        // R2: stopped source freezes the value
        cur_req = "R2";
        clk_sel = 0; tick_en = '1; cnt_en = 1; clr = 1;
        cyc(5);
        check("R2", "frozen", int'(count), 8'hA5);
        clr = 0; dir_down = 1;
        cyc(3);
        idle();

        // R2 + R7: load while stopped
        cur_req = "R7";
        load(8'hFD);

        // R5 + R9: up-count across the wrap
        cur_req = "R9";
        clk_sel = 1; tick_en = 7'b0000001; cnt_en = 1;
        cyc(3);
        check("R9", "wrap to zero", int'(count), 0);
        check("R9", "flag raised", int'(ovf_flag), 1);
        cnt_en = 0;
        cyc(4);
        check("R9", "flag sticky", int'(ovf_flag), 1);

        // R10: acknowledge clears
        cur_req = "R10";
        ovf_ack = 1;
        cyc(1);
        check("R10", "ack clears", int'(ovf_flag), 0);
        ovf_ack = 0;
        load(8'hFF);
        ovf_ack = 1; cnt_en = 1;
        cyc(1);
        check("R10", "wrap beats ack", int'(ovf_flag), 1);
        cnt_en = 0;
        cyc(1);
        check("R10", "ack after", int'(ovf_flag), 0);
        ovf_ack = 0;

        // R5 + R9: down wrap leaves the flag clear
        cur_req = "R5";
        load(1);
        cnt_en = 1; dir_down = 1;
        cyc(2);
        check("R5", "down wrap", int'(count), 255);
        check("R9", "no flag on down wrap", int'(ovf_flag), 0);
        dir_down = 0;

        // R9: load of zero over a wrapping tick sets nothing
        cur_req = "R9";
        cnt_en = 1;
        load(0);
        check("R9", "load over wrap", int'(ovf_flag), 0);

        // R3: each select value with foreign and own tick bits
        cur_req = "R3";
        for (int k = 1; k <= 7; k++) begin
            clk_sel = 3'(k); cnt_en = 1; dir_down = 0;
            tick_en = ~(7'b1 << (k - 1));
            cyc(2);
            tick_en = 7'b1 << (k - 1);
            cyc(2);
        end
        check("R3", "seven sources x2", int'(count), 14);

        // R4: clear with count request present
        cur_req = "R4";
        clk_sel = 4; tick_en = 7'b0001000; clr = 1; cnt_en = 1; dir_down = 1;
        cyc(1);
        check("R4", "clear", int'(count), 0);
        clr = 0;

        // R6: ticks with no count or clear hold
        cur_req = "R6";
        load(8'h3C);
        cnt_en = 0;
        cyc(4);
        check("R6", "hold", int'(count), 8'h3C);
        tick_en = '0; cnt_en = 1;
        cyc(3);

        // full up sweep, then random mix
        cur_req = "R5";
        idle(); clk_sel = 5; tick_en = 7'b0010000; cnt_en = 1;
        cyc(300);
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            clk_sel  = 3'($urandom_range(0, 7));
            tick_en  = 7'($urandom);
            cnt_en   = ($urandom_range(0, 3) != 0);
            dir_down = ($urandom_range(0, 2) == 0);
            clr      = ($urandom_range(0, 15) == 0);
            wr_en    = ($urandom_range(0, 15) == 0);
            wr_data  = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
            ovf_ack  = ($urandom_range(0, 7) == 0);
            cyc(1);
        end
        idle();
        cyc(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule